// File: doc/BRIEF.md
# Pointer-Addressed Data Memory Unit

This unit serves byte loads and stores whose address comes from one of three 16-bit pointer registers, plus a small unsigned displacement. The data space is flat and byte-wide, but only its lowest 1280 addresses hold storage. From the bottom up, they are split into four back-to-back regions: a 32-entry general register file, a 64-byte standard I/O window, a 160-byte extended I/O window and a 1 KiB SRAM. The I/O windows are modelled as plain byte arrays.

Each access occupies exactly two clock cycles. In the first cycle the selected pointer is read from the top six bytes of the register file, the displacement is added, and the result is decoded into a region and a local index. In the second cycle the chosen region is read or written. A caller raises `req_i` for one cycle, which is accepted when the unit is idle, and then waits for the one-cycle `done_o` strobe. The pointers live inside the register file, so a store through any pointer can retarget a pointer for later accesses.

Top module: `dmu_core`

## Requirements
- R1: Addresses 0 to 31 reach the register file. Register r26 is the low byte and r27 the high byte of pointer X. Pointer Y is r29:r28 and pointer Z is r31:r30.
- R2: Addresses 32 to 95 reach the standard I/O array, and its storage is distinct from the other regions.
- R3: Addresses 96 to 255 reach the extended I/O array.
- R4: Addresses 256 to 1279 reach the SRAM. SRAM location 256 does not alias register 0.
- R5: An address of 1280 or more completes with `err_o` high for the same single cycle as `done_o` and returns `rdata_o` = 0x00. A write to such an address changes no stored byte, and no region select is raised.
- R6: The access address is the selected pointer plus `ofs_i` zero-extended, taken modulo 2^16. The `ptr_sel_i` encoding is 0 for X, 1 for Y, and 2 or 3 for Z.
- R7: A request accepted at clock edge k gives `done_o` high for exactly one cycle after edge k+1. Read data is valid with `done_o` and holds until the next completion.
- R8: A request is only accepted while no access is in progress. A request held high during the second cycle of an access is ignored and has no effect on storage.
- R9: A store to addresses 26 to 31 does not change the address of the access that performs it, but does change the pointer used by the next access.
- R10: In the cycle after acceptance, `rgn_sel_o` is one-hot with bit 0 for the register file, bit 1 for standard I/O, bit 2 for extended I/O and bit 3 for SRAM. `wr_en_o` is high in that cycle only for a store to a valid region. Both are zero otherwise.
- R11: After reset, `done_o`, `err_o`, `rgn_sel_o`, `wr_en_o` and `rdata_o` are zero, and every register file byte is zero, so all pointers start at 0.
- R12: A completed store returns `rdata_o` = 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = store, 0 = load |
| ptr_sel_i | input | 2 | Pointer select (0 X, 1 Y, 2/3 Z) |
| ofs_i | input | OFS_W (6) | Unsigned displacement added to the pointer |
| wdata_i | input | DW (8) | Store data |
| rdata_o | output | DW (8) | Load data, valid with done_o |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Out-of-range address, pulses with done_o |
| rgn_sel_o | output | 4 | One-hot region select during the access cycle |
| wr_en_o | output | 1 | Store enable during the access cycle |

## Verification
The select lines `rgn_sel_o` and `wr_en_o` are due one cycle after the accepting edge. The `done_o` strobe, together with `rdata_o` and `err_o`, is due after the following edge. The driver checks the select lines at the falling edge straight after acceptance, and checks that the strobe is present at the next falling edge. The monitor pops each expected load value and error flag from the scoreboard only on a falling edge where `done_o` is high, so an early, late or extra completion shows up as a mismatch or as an empty queue. The expected address is formed from a byte-level model of the four regions, using the pointer values in force before the access. This places pointer self-modification and wraparound in the correct cycle.

// File: rtl/dmu_pkg.sv
package dmu_pkg;

  typedef enum logic [2:0] {
    RG_RF   = 3'd0,
    RG_SIO  = 3'd1,
    RG_XIO  = 3'd2,
    RG_SRAM = 3'd3,
    RG_NONE = 3'd4
  } rgn_e;

  localparam int unsigned NRGN = 4;

  function automatic logic [NRGN-1:0] rgn_onehot(rgn_e r);
    case (r)
      RG_RF:   return 4'b0001;
      RG_SIO:  return 4'b0010;
      RG_XIO:  return 4'b0100;
      RG_SRAM: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/dmu_decode.sv
module dmu_decode
  import dmu_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned IW     = 10,
  parameter int unsigned RF_N   = 32,
  parameter int unsigned SIO_N  = 64,
  parameter int unsigned XIO_N  = 160,
  parameter int unsigned SRAM_N = 1024
) (
  input  logic [AW-1:0] addr,
  output rgn_e          rgn,
  output logic [IW-1:0] idx
);
  localparam int unsigned B_SIO  = RF_N;
  localparam int unsigned B_XIO  = B_SIO + SIO_N;
  localparam int unsigned B_SRAM = B_XIO + XIO_N;
  localparam int unsigned B_END  = B_SRAM + SRAM_N;

  logic [31:0] a;

  always_comb begin
    a   = 32'(addr);
    rgn = RG_NONE;
    idx = '0;
    if (a < B_SIO) begin
      rgn = RG_RF;
      idx = IW'(a);
    end else if (a < B_XIO) begin
      rgn = RG_SIO;
      idx = IW'(a - B_SIO);
    end else if (a < B_SRAM) begin
      rgn = RG_XIO;
      idx = IW'(a - B_XIO);
    end else if (a < B_END) begin
      rgn = RG_SRAM;
      idx = IW'(a - B_SRAM);
    end
  end
endmodule

// File: rtl/dmu_regfile.sv
module dmu_regfile #(
  parameter int unsigned N  = 32,
  parameter int unsigned DW = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic            re,
  input  logic [IW-1:0]   idx,
  input  logic [DW-1:0]   wd,
  output logic [DW-1:0]   q,
  output logic [2*DW-1:0] ptr_x,
  output logic [2*DW-1:0] ptr_y,
  output logic [2*DW-1:0] ptr_z
);
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(N); i++) mem[i] <= '0;
      q <= '0;
    end else begin
      if (we) mem[idx] <= wd;
      if (re) q <= mem[idx];
    end
  end

  // pointer pairs occupy the top six bytes, odd entry is the high byte
  assign ptr_x = {mem[N-5], mem[N-6]};
  assign ptr_y = {mem[N-3], mem[N-4]};
  assign ptr_z = {mem[N-1], mem[N-2]};
endmodule

// File: rtl/dmu_bank.sv
module dmu_bank #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  parameter int unsigned IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/dmu_core.sv
module dmu_core
  import dmu_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned OFS_W  = 6,
  parameter int unsigned RF_N   = 32,
  parameter int unsigned SIO_N  = 64,
  parameter int unsigned XIO_N  = 160,
  parameter int unsigned SRAM_N = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       ptr_sel_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             done_o,
  output logic             err_o,
  output logic [3:0]       rgn_sel_o,
  output logic             wr_en_o
);
  localparam int unsigned AW  = 2 * DW;
  localparam int unsigned IW  = $clog2(SRAM_N > XIO_N ? SRAM_N : XIO_N);
  localparam int unsigned RIW = $clog2(RF_N);
  localparam int unsigned DEP [4] = '{RF_N, SIO_N, XIO_N, SRAM_N};

  logic          busy;
  logic          acc_we;
  logic [DW-1:0] acc_wd;
  rgn_e          acc_rgn;
  logic [IW-1:0] acc_idx;
  rgn_e          rd_src;
  logic [2:0]    acc_code;

  logic [AW-1:0] ptr_x, ptr_y, ptr_z, ptr, nxt_addr;
  rgn_e          dec_rgn;
  logic [IW-1:0] dec_idx;
  logic [DW-1:0] bank_q [4];

  // stage 1: pointer selection and address formation
  always_comb begin
    case (ptr_sel_i)
      2'd0:    ptr = ptr_x;
      2'd1:    ptr = ptr_y;
      default: ptr = ptr_z;
    endcase
  end

  assign nxt_addr = ptr + AW'(ofs_i);

  dmu_decode #(
    .AW(AW), .IW(IW), .RF_N(RF_N), .SIO_N(SIO_N),
    .XIO_N(XIO_N), .SRAM_N(SRAM_N)
  ) u_decode (
    .addr(nxt_addr),
    .rgn (dec_rgn),
    .idx (dec_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      acc_we    <= 1'b0;
      acc_wd    <= '0;
      acc_rgn   <= RG_NONE;
      acc_idx   <= '0;
      rd_src    <= RG_NONE;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      rgn_sel_o <= '0;
      wr_en_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (!busy && req_i) begin
        busy      <= 1'b1;
        acc_we    <= we_i;
        acc_wd    <= wdata_i;
        acc_rgn   <= dec_rgn;
        acc_idx   <= dec_idx;
        rgn_sel_o <= rgn_onehot(dec_rgn);
        wr_en_o   <= we_i && (dec_rgn != RG_NONE);
      end else if (busy) begin
        // stage 2: region access completes on this edge
        busy      <= 1'b0;
        done_o    <= 1'b1;
        err_o     <= (acc_rgn == RG_NONE);
        rd_src    <= acc_we ? RG_NONE : acc_rgn;
        rgn_sel_o <= '0;
        wr_en_o   <= 1'b0;
      end
    end
  end

  assign acc_code = acc_rgn;

  dmu_regfile #(.N(RF_N), .DW(DW), .IW(RIW)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .we   (busy && acc_we && (acc_code == 3'd0)),
    .re   (busy && (acc_code == 3'd0)),
    .idx  (acc_idx[RIW-1:0]),
    .wd   (acc_wd),
    .q    (bank_q[0]),
    .ptr_x(ptr_x),
    .ptr_y(ptr_y),
    .ptr_z(ptr_z)
  );

  for (genvar g = 1; g < 4; g++) begin : g_bank
    localparam int unsigned BIW = $clog2(DEP[g]);
    dmu_bank #(.DEPTH(DEP[g]), .DW(DW), .IW(BIW)) u_bank (
      .clk(clk),
      .we (busy && acc_we && (acc_code == 3'(g))),
      .re (busy && (acc_code == 3'(g))),
      .idx(acc_idx[BIW-1:0]),
      .wd (acc_wd),
      .q  (bank_q[g])
    );
  end

  always_comb begin
    case (rd_src)
      RG_RF:   rdata_o = bank_q[0];
      RG_SIO:  rdata_o = bank_q[1];
      RG_XIO:  rdata_o = bank_q[2];
      RG_SRAM: rdata_o = bank_q[3];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dmu_core_chk.sv
module dmu_core_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_i,
  input logic          busy,
  input logic          done_o,
  input logic          err_o,
  input logic [DW-1:0] rdata_o,
  input logic [3:0]    rgn_sel_o,
  input logic          wr_en_o
);
  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rgn_sel_o));

  assert_wren_has_sel_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (rgn_sel_o != 4'b0000));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (req_i && !busy) |=> ##1 done_o);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  assert_err_zero_R5: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (done_o && rdata_o == '0));
endmodule

bind dmu_core dmu_core_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_i    (req_i),
  .busy     (busy),
  .done_o   (done_o),
  .err_o    (err_o),
  .rdata_o  (rdata_o),
  .rgn_sel_o(rgn_sel_o),
  .wr_en_o  (wr_en_o)
);

// File: tb/test_dmu_core.sv
module test_dmu_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       we = 1'b0;
  logic [1:0] psel = 2'd0;
  logic [5:0] ofs = 6'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       done, err, wr_en;
  logic [3:0] rsel;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dmu_core i_dmu_core (
    .clk(clk), .rst(rst), .req_i(req), .we_i(we), .ptr_sel_i(psel),
    .ofs_i(ofs), .wdata_i(wdata), .rdata_o(rdata), .done_o(done),
    .err_o(err), .rgn_sel_o(rsel), .wr_en_o(wr_en)
  );

  typedef struct {
    logic [7:0] rd;
    logic       er;
    string      tag;
  } exp_t;

  exp_t       sbq[$];
  logic [7:0] mdl [1280];
  logic       prev_done = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ptr_of(int s);
    case (s)
      0:       return {mdl[27], mdl[26]};
      1:       return {mdl[29], mdl[28]};
      default: return {mdl[31], mdl[30]};
    endcase
  endfunction

  function automatic logic [3:0] sel_of(logic [15:0] a);
    if (a < 32)   return 4'b0001;
    if (a < 96)   return 4'b0010;
    if (a < 256)  return 4'b0100;
    if (a < 1280) return 4'b1000;
    return 4'b0000;
  endfunction

  // driver: pushes the expected completion, then drives one access
  task automatic acc(int s, int o, bit w, logic [7:0] d, string tag, bit hold = 1'b0);
    logic [15:0] a;
    exp_t e;
    a = ptr_of(s) + 16'(o);
    e.rd  = (w || a >= 1280) ? 8'h00 : mdl[a];
    e.er  = (a >= 1280);
    e.tag = tag;
    sbq.push_back(e);
    req = 1'b1; we = w; psel = 2'(s); ofs = 6'(o); wdata = d;
    @(negedge clk);
    chk(rsel == sel_of(a), "R10", "rgn_sel", rsel, sel_of(a));
    chk(wr_en == (w && a < 1280), "R10", "wr_en", wr_en, (w && a < 1280));
    chk(done == 1'b0, "R7", "early done", done, 0);
    if (hold) begin
      we = 1'b1; wdata = 8'hEE;
    end else begin
      req = 1'b0;
    end
    @(negedge clk);
    chk(done == 1'b1, "R7", "done due", done, 1);
    req = 1'b0;
    if (w && a < 1280) mdl[a] = d;
  endtask

  task automatic set_ptr(int lo_ofs, logic [15:0] v);
    acc(2, lo_ofs, 1'b1, v[7:0], "R1");
    acc(2, lo_ofs + 1, 1'b1, v[15:8], "R1");
  endtask

  // monitor: compares completions against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done && done) chk(1'b0, "R7", "done wider than one cycle", 1, 0);
      if (done) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R8", "unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(rdata == e.rd, e.tag, "rdata", rdata, e.rd);
          chk(err == e.er, e.tag, "err", err, e.er);
        end
      end
      prev_done <= done;
    end
  end

  initial begin
    #(8 * 50000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1280; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(done == 0, "R11", "done", done, 0);
    chk(err == 0, "R11", "err", err, 0);
    chk(rsel == 0, "R11", "rgn_sel", rsel, 0);
    chk(wr_en == 0, "R11", "wr_en", wr_en, 0);
    chk(rdata == 0, "R11", "rdata", rdata, 0);
    acc(1, 29, 1'b0, 8'h00, "R11");           // Y high byte is zero

    // register file, R12 on the store
    acc(2, 0, 1'b1, 8'hA5, "R1/R12");
    acc(2, 0, 1'b0, 8'h00, "R1");
    acc(2, 31, 1'b0, 8'h00, "R1");
    // standard I/O
    acc(2, 32, 1'b1, 8'h5A, "R2");
    acc(2, 63, 1'b1, 8'hC3, "R2");
    acc(2, 32, 1'b0, 8'h00, "R2");
    acc(2, 63, 1'b0, 8'h00, "R2");
    // boundary 95/96 through Y
    set_ptr(28, 16'd95);
    acc(1, 0, 1'b1, 8'h11, "R2");
    acc(1, 1, 1'b1, 8'h22, "R3");
    acc(1, 0, 1'b0, 8'h00, "R2");
    acc(1, 1, 1'b0, 8'h00, "R3");
    // boundary 255/256
    set_ptr(28, 16'd192);
    acc(1, 63, 1'b1, 8'h33, "R3");
    acc(1, 63, 1'b0, 8'h00, "R3");
    set_ptr(28, 16'd256);
    acc(1, 0, 1'b1, 8'h44, "R4");
    acc(1, 0, 1'b0, 8'h00, "R4");
    acc(2, 0, 1'b0, 8'h00, "R4");             // r0 still A5
    // top of SRAM and first unpopulated address
    set_ptr(28, 16'd1216);
    acc(1, 63, 1'b1, 8'h55, "R4");
    acc(1, 63, 1'b0, 8'h00, "R4");
    set_ptr(28, 16'd1217);
    acc(1, 63, 1'b1, 8'h77, "R5");
    acc(1, 63, 1'b0, 8'h00, "R5");
    set_ptr(28, 16'hFFF0);
    acc(1, 0, 1'b0, 8'h00, "R5");
    set_ptr(28, 16'd1216);
    acc(1, 63, 1'b0, 8'h00, "R5");            // 1279 unchanged
    acc(2, 0, 1'b0, 8'h00, "R5");             // r0 unchanged
    // wraparound and pointer select 3
    set_ptr(26, 16'hFFFF);
    acc(0, 1, 1'b0, 8'h00, "R6");
    acc(3, 32, 1'b0, 8'h00, "R6");
    acc(0, 33, 1'b0, 8'h00, "R6");            // wraps to 32
    // request held during access is ignored
    acc(2, 40, 1'b1, 8'h66, "R8", 1'b1);
    acc(2, 40, 1'b0, 8'h00, "R8");
    repeat (3) @(negedge clk);
    chk(rdata == 8'h66, "R7", "rdata held", rdata, 8'h66);
    chk(sbq.size() == 0, "R8", "pending items", sbq.size(), 0);
    // self-modifying pointer
    set_ptr(26, 16'h0000);
    acc(0, 26, 1'b1, 8'h20, "R9");            // targets r26 itself
    acc(0, 0, 1'b0, 8'h00, "R9");             // now reads address 32
    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R7", "pending items", sbq.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule